// File: doc/BRIEF.md
# CEC Bus Frame Transmitter with Arbitration

This block sends one buffered CEC frame of 1 to 16 bytes on a single open-drain line. A microsecond tick comes from a clock divider whose ratio is a parameter. All phase lengths are parameters counted in ticks. The block's output `line_drive` pulls the line low when it is high. `line_in` is the level read back from the wired line, and it includes the block's own drive.

After a start request is accepted, the block captures the bytes, the length and the idle requirement. It then waits until the line has been high for long enough and sends a start bit. Each byte follows as ten bit slots.

While it sends, the block watches the line at a fixed sample point:
- In the leading slots it detects that another sender has won the bus.
- In every acknowledge slot it reads whether the frame was acknowledged.
- At the end of each sampled slot it checks for a line held low by another device to signal an error.

Each attempt ends with exactly one status code and a one-cycle `done` pulse. Retries are left to the surrounding logic.

Top module: `cec_tx_arb`

## Requirements
- R1: While reset is held, and after it is released, `line_drive` and `done` are 0 and `status` is 0 (none).
- R2: A start bit begins only after `line_in` has been high for more than `free_bits` whole bit periods (T_BIT ticks each). This count restarts on every tick that sees `line_in` low. A low pulse while waiting delays the start, and the request stays pending.
- R3: The start bit drives the line low for T_START_LO ticks and releases it until T_START_ALL ticks after its falling edge.
- R4: A 0 bit is driven low for T_ZERO_LO ticks and a 1 bit for T_ONE_LO ticks. Every bit period lasts T_BIT ticks. The block drives the line only while a frame is in progress.
- R5: Bytes go out in order, starting with `msg_data[7:0]` and then each following 8-bit group. Each byte uses ten slots:
  - slots 0 to 7 carry the data, most significant bit first;
  - slot 8 is 1 only on byte `msg_len`-1;
  - slot 9 is always sent as 1.
- R6: In slots 0 to 3 of the first byte, a 1 bit is sampled T_SAMPLE ticks after its falling edge. If the sample is low, the block releases the line at once, sends nothing further and reports status 2 (arbitration lost).
- R7: Every acknowledge slot is sampled at T_SAMPLE. The frame is broadcast when the low nibble of the first byte is 4'hF. A directed frame is acknowledged by a low sample and a broadcast frame by a high sample.
- R8: On a missing acknowledge, the block completes that bit period, reports status 3 (no acknowledge) and sends no further bytes.
- R9: If `line_in` is low on the last tick of a sampled slot, the block reports status 4 (low drive). It then accepts no new request until `line_in` is high.
- R10: After the acknowledge slot of the last byte, the block reports status 1 (OK) at the end of that bit period and returns to idle.
- R11: Every status code is issued together with a `done` pulse exactly one cycle long, and `status` holds its value between pulses.
- R12: A start request is ignored while an attempt is in progress, and also when `msg_len` is 0 or greater than MAX_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send the frame presented on the message inputs |
| msg_len | input | $clog2(MAX_BYTES+1) | Number of bytes, 1 to MAX_BYTES |
| msg_data | input | 8*MAX_BYTES | Frame bytes; byte k is bits [8k+7:8k] |
| free_bits | input | FREE_W | Idle requirement in whole bit periods |
| line_in | input | 1 | Level read back from the shared line |
| line_drive | output | 1 | 1 pulls the line low |
| status | output | 3 | 0 none, 1 OK, 2 arbitration lost, 3 no acknowledge, 4 low drive |
| done | output | 1 | One-cycle pulse when `status` is updated |

## Verification
The assertions take `line_in` to be the wired level of the line. Whenever `line_drive` is 1, `line_in` is 0.

The bench keeps to this by building `line_in` as the inverse of the OR of `line_drive` and its own pull-down. Its pull-down is timed from the reference model's frame position, which lets it act as:
- an acknowledging receiver;
- a competing sender with a smaller address;
- a device signalling an error.

Requests are held for one cycle. Some are placed deliberately inside busy periods, and some carry a zero length.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_WAIT,
    TX_SLO,
    TX_SHI,
    TX_BIT,
    TX_LDW
  } tx_state_e;

  typedef enum logic [2:0] {
    RES_NONE   = 3'd0,
    RES_OK     = 3'd1,
    RES_ARB    = 3'd2,
    RES_NACK   = 3'd3,
    RES_LOWDRV = 3'd4
  } tx_result_e;

  // Level carried by a slot: data bits MSB first, then end flag, then ack.
  function automatic logic slot_level(input logic [7:0] data,
                                      input logic [3:0] slot,
                                      input logic       last);
    if (slot < 4'd8) return data[3'd7 - slot[2:0]];
    else if (slot == 4'd8) return last;
    else return 1'b1;
  endfunction

  // A released slot is watched when it may be overwritten by others.
  function automatic logic slot_watched(input logic       level,
                                        input logic       first_byte,
                                        input logic [3:0] slot);
    return level && ((first_byte && slot < 4'd4) || slot == 4'd9);
  endfunction

  // Acknowledge decision: polarity flips for broadcast.
  function automatic logic ack_ok(input logic bcast, input logic level);
    return bcast ? level : !level;
  endfunction

endpackage

// File: rtl/cec_tick_gen.sv
module cec_tick_gen #(
  parameter int CLK_PER_TICK = 50,
  localparam int DW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (div_q == DW'(CLK_PER_TICK - 1)) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == DW'(CLK_PER_TICK - 1));
endmodule

// File: rtl/cec_free_timer.sv
module cec_free_timer #(
  parameter int T_BIT  = 2400,
  parameter int FREE_W = 4,
  localparam int SUB_W = $clog2(T_BIT),
  localparam int PER_W = FREE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_in,
  input  logic [FREE_W-1:0] need,
  output logic              free_ok
);
  logic [SUB_W-1:0] sub_q;
  logic [PER_W-1:0] per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      per_q <= '0;
    end else if (!line_in) begin
      sub_q <= '0;
      per_q <= '0;
    end else if (tick) begin
      if (sub_q == SUB_W'(T_BIT - 1)) begin
        sub_q <= '0;
        if (per_q != {PER_W{1'b1}}) per_q <= per_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign free_ok = (per_q > {1'b0, need});
endmodule

// File: rtl/cec_msg_buf.sv
module cec_msg_buf #(
  parameter int MAX_BYTES = 16,
  localparam int LEN_W  = $clog2(MAX_BYTES + 1),
  localparam int BYTE_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [LEN_W-1:0]       len_in,
  input  logic [8*MAX_BYTES-1:0] data_in,
  input  logic [BYTE_W-1:0]      byte_idx,
  output logic [7:0]             cur_byte,
  output logic                   last_byte,
  output logic                   bcast
);
  logic [7:0]       mem [MAX_BYTES];
  logic [LEN_W-1:0] len_q;

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[k] <= '0;
      else if (load) mem[k] <= data_in[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else if (load) len_q <= len_in;
  end

  assign cur_byte  = mem[byte_idx];
  assign last_byte = (LEN_W'(byte_idx) + LEN_W'(1)) == len_q;
  assign bcast     = (mem[0][3:0] == 4'hF);
endmodule

// File: rtl/cec_tx_arb.sv
module cec_tx_arb
  import cec_tx_pkg::*;
#(
  parameter int CLK_PER_TICK = 50,
  parameter int T_START_LO   = 3700,
  parameter int T_START_ALL  = 4500,
  parameter int T_ZERO_LO    = 1500,
  parameter int T_ONE_LO     = 600,
  parameter int T_BIT        = 2400,
  parameter int T_SAMPLE     = 850,
  parameter int MAX_BYTES    = 16,
  parameter int FREE_W       = 4,
  localparam int LEN_W       = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LEN_W-1:0]       msg_len,
  input  logic [8*MAX_BYTES-1:0] msg_data,
  input  logic [FREE_W-1:0]      free_bits,
  input  logic                   line_in,
  output logic                   line_drive,
  output logic [2:0]             status,
  output logic                   done
);
  localparam int T_TOP  = (T_START_ALL > T_BIT) ? T_START_ALL : T_BIT;
  localparam int CNT_W  = $clog2(T_TOP + 1);
  localparam int BYTE_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  tx_state_e         st_q;
  tx_result_e        res_q;
  logic              done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] byte_q;
  logic [3:0]        slot_q;
  logic              nack_q;
  logic [FREE_W-1:0] need_q;

  logic              tick;
  logic              free_ok;
  logic              load;
  logic [7:0]        cur_byte;
  logic              last_byte;
  logic              bcast;

  // Named internal events
  logic              bit_val;
  logic              watched;
  logic [CNT_W-1:0]  low_len;
  logic              ev_sample;
  logic              ev_end;
  logic              ev_arb;
  logic              ev_nack;
  logic              ev_lowdrv;
  logic              frame_on;
  logic              ld_wait;

  cec_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  cec_free_timer #(.T_BIT(T_BIT), .FREE_W(FREE_W)) u_free (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
    .need(need_q), .free_ok(free_ok)
  );

  assign load = (st_q == TX_IDLE) && start && (msg_len != '0) &&
                (msg_len <= LEN_W'(MAX_BYTES));

  cec_msg_buf #(.MAX_BYTES(MAX_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(load), .len_in(msg_len),
    .data_in(msg_data), .byte_idx(byte_q), .cur_byte(cur_byte),
    .last_byte(last_byte), .bcast(bcast)
  );

  assign bit_val   = slot_level(cur_byte, slot_q, last_byte);
  assign watched   = slot_watched(bit_val, byte_q == '0, slot_q);
  assign low_len   = bit_val ? CNT_W'(T_ONE_LO) : CNT_W'(T_ZERO_LO);
  assign ev_sample = tick && (st_q == TX_BIT) && (cnt_q == CNT_W'(T_SAMPLE)) && watched;
  assign ev_end    = tick && (st_q == TX_BIT) && (cnt_q == CNT_W'(T_BIT - 1));
  assign ev_arb    = ev_sample && (slot_q != 4'd9) && !line_in;
  assign ev_nack   = ev_sample && (slot_q == 4'd9) && !ack_ok(bcast, line_in);
  assign ev_lowdrv = ev_end && watched && !line_in;
  assign frame_on  = (st_q == TX_SLO) || (st_q == TX_SHI) || (st_q == TX_BIT);
  assign ld_wait   = (st_q == TX_LDW);

  assign line_drive = (st_q == TX_SLO) || ((st_q == TX_BIT) && (cnt_q < low_len));
  assign status     = res_q;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      res_q  <= RES_NONE;
      done_q <= 1'b0;
      cnt_q  <= '0;
      byte_q <= '0;
      slot_q <= '0;
      nack_q <= 1'b0;
      need_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        TX_IDLE: begin
          if (load) begin
            need_q <= free_bits;
            st_q   <= TX_WAIT;
          end
        end
        TX_WAIT: begin
          if (tick && free_ok && line_in) begin
            st_q  <= TX_SLO;
            cnt_q <= '0;
          end
        end
        TX_SLO: begin
          if (tick) begin
            if (cnt_q == CNT_W'(T_START_LO - 1)) begin
              st_q  <= TX_SHI;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        TX_SHI: begin
          if (tick) begin
            if (cnt_q == CNT_W'(T_START_ALL - T_START_LO - 1)) begin
              st_q   <= TX_BIT;
              cnt_q  <= '0;
              byte_q <= '0;
              slot_q <= '0;
              nack_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        TX_BIT: begin
          if (ev_arb) begin
            res_q  <= RES_ARB;
            done_q <= 1'b1;
            st_q   <= TX_IDLE;
          end else if (ev_end) begin
            if (ev_lowdrv) begin
              res_q  <= RES_LOWDRV;
              done_q <= 1'b1;
              st_q   <= TX_LDW;
            end else if (nack_q) begin
              res_q  <= RES_NACK;
              done_q <= 1'b1;
              st_q   <= TX_IDLE;
            end else if (slot_q == 4'd9 && last_byte) begin
              res_q  <= RES_OK;
              done_q <= 1'b1;
              st_q   <= TX_IDLE;
            end else begin
              cnt_q <= '0;
              if (slot_q == 4'd9) begin
                slot_q <= '0;
                byte_q <= byte_q + 1'b1;
              end else begin
                slot_q <= slot_q + 1'b1;
              end
            end
          end else begin
            if (ev_nack) nack_q <= 1'b1;
            if (tick) cnt_q <= cnt_q + 1'b1;
          end
        end
        TX_LDW: begin
          if (line_in) st_q <= TX_IDLE;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cec_tx_arb_chk.sv
module cec_tx_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_in,
  input logic       line_drive,
  input logic [2:0] status,
  input logic       done,
  input logic       frame_on,
  input logic       free_ok,
  input logic       ld_wait,
  input logic       ev_end
);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != 3'd0 && status <= 3'd4));

  a_r11_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status));

  a_r4_drive_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive |-> frame_on);

  a_r2_launch_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_on) |-> $past(free_ok));

  a_r9_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wait && !line_in) |=> ld_wait);

  a_r6_arb_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd2) |-> !line_drive);

  a_r8_nack_period_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd3) |-> $past(ev_end));
endmodule

bind cec_tx_arb cec_tx_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_drive(line_drive),
  .status(status), .done(done), .frame_on(frame_on), .free_ok(free_ok),
  .ld_wait(ld_wait), .ev_end(ev_end)
);

// File: tb/cec_tx_arb_test.sv
module cec_tx_arb_test;
  localparam int PERIOD = 10;
  localparam int TSL = 74, TSA = 90, T0 = 30, T1 = 12, TB = 48, TS = 17;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [4:0]   msg_len = '0;
  logic [127:0] msg_data = '0;
  logic [3:0]   free_bits = '0;
  logic         line_drive, done;
  logic [2:0]   status;
  logic         man_low = 1'b0;
  logic         resp_low = 1'b0;
  logic         line_in;

  int checks = 0, fails = 0;
  bit finished = 0;

  assign line_in = !(line_drive || man_low || resp_low);

  always #(PERIOD/2) clk = ~clk;

  cec_tx_arb #(.CLK_PER_TICK(1), .T_START_LO(TSL), .T_START_ALL(TSA),
               .T_ZERO_LO(T0), .T_ONE_LO(T1), .T_BIT(TB), .T_SAMPLE(TS),
               .MAX_BYTES(16), .FREE_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len),
    .msg_data(msg_data), .free_bits(free_bits), .line_in(line_in),
    .line_drive(line_drive), .status(status), .done(done)
  );

  // ---------------- reference model ----------------
  int     m_state = 0;  // 0 idle, 1 waiting, 2 frame, 3 low-drive wait
  int     m_t = 0, m_hi = 0, m_len = 0, m_need = 0, m_status = 0;
  bit     m_done = 0, m_nack = 0;
  byte    m_bytes[$];

  function automatic int lvl(int b);
    int by = b / 10, s = b % 10;
    if (s < 8) return (m_bytes[by] >> (7 - s)) & 1;
    if (s == 8) return (by == m_len - 1) ? 1 : 0;
    return 1;
  endfunction

  function automatic bit exp_drive();
    int b, p;
    if (m_state != 2) return 0;
    if (m_t < TSL) return 1;
    if (m_t < TSA) return 0;
    b = (m_t - TSA) / TB;
    p = (m_t - TSA) % TB;
    return p < ((lvl(b) == 1) ? T1 : T0);
  endfunction

  task automatic finish_m(int code, int nxt);
    m_status = code;
    m_done = 1;
    m_state = nxt;
  endtask

  always @(posedge clk) begin
    bit lin;
    lin = line_in;
    if (!rst_n) begin
      m_state = 0; m_t = 0; m_hi = 0; m_status = 0; m_done = 0;
    end else begin
      m_done = 0;
      case (m_state)
        0: if (start && msg_len >= 1 && msg_len <= 16) begin
             m_len = msg_len;
             m_need = free_bits;
             m_bytes = {};
             for (int k = 0; k < 16; k++) m_bytes.push_back(msg_data[8*k +: 8]);
             m_state = 1;
           end
        1: if (lin && (m_hi / TB) > m_need) begin
             m_state = 2; m_t = 0; m_nack = 0;
           end
        2: begin
             if (m_t < TSA) m_t++;
             else begin
               int b, p, v;
               bit samp, bc;
               b = (m_t - TSA) / TB;
               p = (m_t - TSA) % TB;
               v = lvl(b);
               samp = (v == 1) && (b < 4 || b % 10 == 9);
               bc = (m_bytes[0] & 8'h0F) == 8'h0F;
               if (p == TS && samp && b % 10 != 9 && !lin) finish_m(2, 0);
               else if (p == TB - 1) begin
                 if (samp && !lin) finish_m(4, 3);
                 else if (m_nack) finish_m(3, 0);
                 else if (b % 10 == 9 && b / 10 == m_len - 1) finish_m(1, 0);
                 else m_t++;
               end else begin
                 if (p == TS && samp && b % 10 == 9 && (bc ? !lin : lin)) m_nack = 1;
                 m_t++;
               end
             end
           end
        3: if (lin) m_state = 0;
        default: m_state = 0;
      endcase
      m_hi = lin ? m_hi + 1 : 0;
    end
  end

  // ---------------- responder (other devices on the line) ----------------
  int resp_ack_mask = 0;   // bit k: pull ack slot of byte k low
  int resp_arb_slot = -1;  // slot of byte 0 where a rival pulls low
  bit resp_ld = 0;         // hold line low from byte 0 ack slot
  int ld_cnt = 0;

  always @(negedge clk) begin
    bit r;
    r = 0;
    if (m_state == 2 && m_t >= TSA) begin
      int b, p;
      b = (m_t - TSA) / TB;
      p = (m_t - TSA) % TB;
      if (b % 10 == 9 && p < T0 && ((resp_ack_mask >> (b / 10)) & 1)) r = 1;
      if (b == resp_arb_slot && p < T0) r = 1;
      if (resp_ld && b == 9 && p == 0) ld_cnt = 72;
    end
    if (ld_cnt > 0) begin r = 1; ld_cnt--; end
    resp_low = r;
  end

  // ---------------- per-cycle comparison ----------------
  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3/R4/R5 line_drive", line_drive, exp_drive());
      chk("R11 done", done, m_done);
      chk("R6/R7/R8/R9/R10 status", status, m_status);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(int len, logic [127:0] data, int need);
    @(negedge clk);
    msg_len = len[4:0]; msg_data = data; free_bits = need[3:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string req, int exp);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(req, done ? status : -1, exp);
    @(negedge clk);
  endtask

  task automatic run_len(int level, output int n);
    n = 0;
    while (line_drive == level[0] && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 drive in reset", line_drive, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 status in reset", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", status, 0);
    chk("R1 drive after reset", line_drive, 0);

    // Directed two-byte frame, acknowledged: timing of start and data bits
    resp_ack_mask = 3;
    send(2, 128'hA540, 1);
    n = 0;
    while (!line_drive && n < 5000) begin @(negedge clk); n++; end
    run_len(1, n); chk("R3 start low", n, TSL);
    run_len(0, n); chk("R3 start high", n, TSA - TSL);
    run_len(1, n); chk("R4 zero low", n, T0);
    run_len(0, n); chk("R4 zero high", n, TB - T0);
    // R12: request during a frame is ignored
    @(negedge clk); start = 1'b1; msg_len = 5'd1; msg_data = 128'hFF;
    @(negedge clk); start = 1'b0;
    run_len(1, n);
    run_len(0, n); chk("R4 one high", n, TB - T1);
    wait_done("R10 OK two bytes", 1);

    // Broadcast, nobody pulls low: acknowledged
    resp_ack_mask = 0;
    send(1, 128'h4F, 0);
    wait_done("R7 broadcast high ack", 1);
    // Broadcast, a receiver pulls low: rejected
    resp_ack_mask = 1;
    send(1, 128'h4F, 0);
    wait_done("R7 broadcast low nack", 3);

    // Directed three bytes, only the header acknowledged
    send(3, 128'h221140, 0);
    wait_done("R8 nack stops frame", 3);

    // Arbitration lost in slot 2
    resp_ack_mask = 3; resp_arb_slot = 2;
    send(2, 128'h0075, 0);
    wait_done("R6 arbitration lost", 2);
    resp_arb_slot = -1;

    // Low drive after the header's ack slot
    resp_ack_mask = 0; resp_ld = 1;
    send(2, 128'h0040, 0);
    wait_done("R9 low drive", 4);
    resp_ld = 0;
    send(1, 128'h40, 0);  // R9/R12: arrives while line is still held low
    repeat (200) @(negedge clk);
    chk("R9 no frame after low drive", line_drive, 0);

    // Zero-length request ignored
    send(0, 128'h40, 0);
    n = 0;
    repeat (300) begin @(negedge clk); if (line_drive || done) n++; end
    chk("R12 zero length ignored", n, 0);

    // Signal-free time with a glitch while waiting
    resp_ack_mask = 1;
    @(negedge clk); man_low = 1'b1;
    send(1, 128'h40, 3);
    repeat (5) @(negedge clk);
    man_low = 1'b0;
    repeat (100) @(negedge clk);
    chk("R2 no start during wait", line_drive, 0);
    man_low = 1'b1;
    @(negedge clk); man_low = 1'b0;
    n = 0;
    while (!line_drive && n < 5000) begin @(negedge clk); n++; end
    chk("R2 free time after glitch", n, 4 * TB + 1);
    wait_done("R10 OK after wait", 1);

    repeat (20) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule